// File: doc/BRIEF.md
# Double-Width Integer Divider with Fault Detection

This block is a multi-cycle integer divider for a processor execution pipeline. It divides a dividend made of a high half and a low half by a divisor half as wide as the dividend. It works in unsigned or in two's-complement signed mode, at one of three operand sizes: 8 bits, half the datapath width, or the full datapath width. A single-cycle `start` pulse presents the operands, the mode and the size. Some cycles later a single-cycle `done` pulse returns either a quotient and a remainder, or a divide fault with both results forced to zero. The fault covers a zero divisor and any quotient that does not fit the selected width.

The core is a restoring shift-and-subtract loop that produces one quotient bit per clock. Signed division works on magnitudes and corrects the signs at the end. A quotient that is out of range is caught before the loop starts when the high half alone shows it. Otherwise the signed range check catches it after the loop. Flags are not produced.

Top module: `div_engine`

## Requirements
- R1: After reset, `done`, `busy`, `fault`, `quotient`, `remainder` and `byte_result` are all zero.
- R2: A divisor whose low n bits are zero gives `fault`=1, and `done` rises after the second rising edge, counting the edge that accepts `start` as the first.
- R3: In unsigned mode, a high half (low n bits) greater than or equal to the divisor gives a fault with the same early timing as R2, before any iteration.
- R4: Size code 0 selects n=8, code 1 selects n=W/2, and codes 2 and 3 select n=W. The dividend is {hi[n-1:0], lo[n-1:0]}. In unsigned mode `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, both zero-extended. A zero high half reduces this to lo/divisor.
- R5: With no early fault, `done` rises after the (n+2)th rising edge, counting the accepting edge as the first. The loop takes exactly n iterations.
- R6: In signed mode, the dividend (2n bits) and the divisor (n bits) are two's-complement values. The quotient is negated when their signs differ, and the remainder takes the sign of the dividend. Both are returned as n-bit patterns, zero-extended.
- R7: In signed mode, a negative quotient may have a magnitude up to and including 2^(n-1), and a positive quotient must be below 2^(n-1). Any other result faults at the R5 timing. When the dividend's high-half magnitude is greater than or equal to the divisor magnitude, the fault is raised early, at the R2 timing.
- R8: When `fault` is 1, `quotient` and `remainder` are zero. `fault` only rises together with `done`.
- R9: `done` lasts exactly one cycle. `quotient`, `remainder`, `fault` and `byte_result` hold their values until the next `done`.
- R10: `busy` is 1 from the accepting edge until the edge that raises `done`. A `start` while `busy` is 1 is ignored and does not change the result or its timing.
- R11: `byte_result` equals {remainder[7:0], quotient[7:0]}, the packed result for byte mode.
- R12: Bits of `dvd_hi`, `dvd_lo` and `divisor` above bit n-1 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept operands when not busy |
| size_sel | input | 2 | 0: 8 bit, 1: W/2, 2 or 3: W |
| signed_mode | input | 1 | 1 selects two's-complement division |
| dvd_hi | input | W | High half of the dividend |
| dvd_lo | input | W | Low half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault of the last operation |
| quotient | output | W | Quotient, zero-extended from n bits |
| remainder | output | W | Remainder, zero-extended from n bits |
| byte_result | output | 16 | Remainder byte over quotient byte |

## Verification
Results arrive at one of two fixed times after the accepting edge. An early fault arrives after the second rising edge. Every other result, including a late signed range fault, arrives after edge n+2. The bench raises `start` at a falling edge and then counts falling edges until `done` is seen. It compares that count with the timing the reference model predicts, and it reads the outputs only at that falling edge. One falling edge later it checks that `done` has dropped and that the results have held. Stray `start` pulses are inserted in the middle of a run, and the bench checks that they change neither the values nor the count.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2,
        SZ_ALT  = 2'd3
    } div_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    // operand width selected by the size code for a datapath of w bits
    function automatic int unsigned size_bits(input div_size_e sz, input int unsigned w);
        case (sz)
            SZ_BYTE: return 8;
            SZ_HALF: return w / 2;
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  div_size_e      sz,
    input  logic           sgn,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   dvs,
    output logic [CW-1:0]  nbits,
    output logic [W-1:0]   rem0,
    output logic [W-1:0]   lo0,
    output logic [W-1:0]   dmag,
    output logic           neg_q,
    output logic           neg_r,
    output logic           pre_fault
);
    localparam int unsigned DW = 2 * W;

    int unsigned   nb;
    logic [W:0]    mask_w;
    logic [W-1:0]  mask_n;
    logic [W-1:0]  hi_n, lo_n, d_n, hmag, lmag;
    logic [DW:0]   mask2_w;
    logic [DW-1:0] cat, mag;
    logic          dvd_neg, dvs_neg;

    always_comb begin
        nb      = size_bits(sz, W);
        mask_w  = ({{W{1'b0}}, 1'b1} << nb) - {{W{1'b0}}, 1'b1};
        mask_n  = mask_w[W-1:0];
        hi_n    = hi & mask_n;
        lo_n    = lo & mask_n;
        d_n     = dvs & mask_n;
        cat     = ({{W{1'b0}}, hi_n} << nb) | {{W{1'b0}}, lo_n};
        mask2_w = ({{DW{1'b0}}, 1'b1} << (2 * nb)) - {{DW{1'b0}}, 1'b1};
        dvd_neg = sgn & ((hi_n >> (nb - 1)) != '0);
        dvs_neg = sgn & ((d_n >> (nb - 1)) != '0);
        mag     = dvd_neg ? ((~cat + {{(DW-1){1'b0}}, 1'b1}) & mask2_w[DW-1:0]) : cat;
        hmag    = W'(mag >> nb);
        lmag    = mag[W-1:0] & mask_n;
        dmag    = dvs_neg ? ((~d_n + {{(W-1){1'b0}}, 1'b1}) & mask_n) : d_n;
        pre_fault = (d_n == '0) || (hmag >= dmag);
        rem0    = hmag;
        lo0     = lmag << (W - nb);
        nbits   = CW'(nb);
        neg_q   = dvd_neg ^ dvs_neg;
        neg_r   = dvd_neg;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dv,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] lo_nx
);
    logic [W:0] wide, diff;
    logic       take;

    always_comb begin
        wide   = {rem, lo[W-1]};
        diff   = wide - {1'b0, dv};
        take   = (wide >= {1'b0, dv});
        rem_nx = take ? diff[W-1:0] : wide[W-1:0];
        lo_nx  = {lo[W-2:0], take};
    end
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [CW-1:0] nbits,
    input  logic          sgn,
    input  logic          neg_q,
    input  logic          neg_r,
    input  logic [W-1:0]  q_mag,
    input  logic [W-1:0]  r_mag,
    output logic [W-1:0]  q,
    output logic [W-1:0]  r,
    output logic          rng_fault
);
    logic [W:0]   mask_w, half_w;
    logic [W-1:0] mask_n, half, qm, rm;

    always_comb begin
        mask_w    = ({{W{1'b0}}, 1'b1} << nbits) - {{W{1'b0}}, 1'b1};
        mask_n    = mask_w[W-1:0];
        half_w    = {{W{1'b0}}, 1'b1} << (nbits - CW'(1));
        half      = half_w[W-1:0];
        qm        = q_mag & mask_n;
        rm        = r_mag & mask_n;
        rng_fault = sgn & (neg_q ? (qm > half) : (qm >= half));
        q = (sgn & neg_q) ? ((~qm + {{(W-1){1'b0}}, 1'b1}) & mask_n) : qm;
        r = (sgn & neg_r) ? ((~rm + {{(W-1){1'b0}}, 1'b1}) & mask_n) : rm;
    end
endmodule

// File: rtl/div_engine.sv
module div_engine
    import div_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   size_sel,
    input  logic         signed_mode,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         fault,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic [15:0]  byte_result
);
    localparam int unsigned CW = $clog2(W + 1);

    div_state_e    state;
    logic [CW-1:0] cnt, n_q;
    logic [W-1:0]  rem_q, lo_q, div_q;
    logic          sgn_q, negq_q, negr_q, pend_fault;

    logic [CW-1:0] p_n;
    logic [W-1:0]  p_rem, p_lo, p_dmag;
    logic          p_negq, p_negr, p_fault;
    logic [W-1:0]  s_rem, s_lo;
    logic [W-1:0]  f_q, f_r;
    logic          f_rng;

    div_prep #(.W(W), .CW(CW)) u_prep (
        .sz       (div_size_e'(size_sel)),
        .sgn      (signed_mode),
        .hi       (dvd_hi),
        .lo       (dvd_lo),
        .dvs      (divisor),
        .nbits    (p_n),
        .rem0     (p_rem),
        .lo0      (p_lo),
        .dmag     (p_dmag),
        .neg_q    (p_negq),
        .neg_r    (p_negr),
        .pre_fault(p_fault)
    );

    div_step #(.W(W)) u_step (
        .rem   (rem_q),
        .lo    (lo_q),
        .dv    (div_q),
        .rem_nx(s_rem),
        .lo_nx (s_lo)
    );

    div_fixup #(.W(W), .CW(CW)) u_fix (
        .nbits    (n_q),
        .sgn      (sgn_q),
        .neg_q    (negq_q),
        .neg_r    (negr_q),
        .q_mag    (lo_q),
        .r_mag    (rem_q),
        .q        (f_q),
        .r        (f_r),
        .rng_fault(f_rng)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            n_q        <= '0;
            rem_q      <= '0;
            lo_q       <= '0;
            div_q      <= '0;
            sgn_q      <= 1'b0;
            negq_q     <= 1'b0;
            negr_q     <= 1'b0;
            pend_fault <= 1'b0;
            done       <= 1'b0;
            fault      <= 1'b0;
            quotient   <= '0;
            remainder  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sgn_q  <= signed_mode;
                        negq_q <= p_negq;
                        negr_q <= p_negr;
                        n_q    <= p_n;
                        rem_q  <= p_rem;
                        lo_q   <= p_lo;
                        div_q  <= p_dmag;
                        cnt    <= p_n;
                        pend_fault <= p_fault;
                        state  <= p_fault ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= s_rem;
                    lo_q  <= s_lo;
                    cnt   <= cnt - CW'(1);
                    if (cnt == CW'(1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (pend_fault || f_rng) begin
                        fault     <= 1'b1;
                        quotient  <= '0;
                        remainder <= '0;
                    end else begin
                        fault     <= 1'b0;
                        quotient  <= f_q;
                        remainder <= f_r;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign byte_result = {remainder[7:0], quotient[7:0]};

endmodule

// File: rtl/div_engine_chk.sv
module div_engine_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         fault,
    input logic [W-1:0] divisor,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(fault)));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (quotient == '0 && remainder == '0));

    assert_fault_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> done);

    assert_zero_div_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=> ##1 (done && fault));

    assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

bind div_engine div_engine_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder)
);

// File: tb/tb_div_engine.sv
module tb_div_engine;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   size_sel = 2'd0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic         busy, done, fault;
    logic [W-1:0] quotient, remainder;
    logic [15:0]  byte_result;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    div_engine #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
        .signed_mode(signed_mode), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
        .divisor(divisor), .busy(busy), .done(done), .fault(fault),
        .quotient(quotient), .remainder(remainder), .byte_result(byte_result)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected behaviour from the requirements
    function automatic void model(input logic [1:0] sz, input bit sg,
                                  input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv,
                                  output logic [31:0] q, output logic [31:0] r,
                                  output bit f, output int lat);
        int n;
        logic [63:0] mask, mask2, hn, ln, dn, dvd, dmag, vmag, qm, rm, half;
        bit dneg, vneg;
        n     = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask  = (64'd1 << n) - 64'd1;
        mask2 = (64'd1 << (2 * n)) - 64'd1;
        hn = {32'd0, hi} & mask;
        ln = {32'd0, lo} & mask;
        dn = {32'd0, dv} & mask;
        dvd  = (hn << n) | ln;
        dneg = sg && dvd[2*n-1];
        vneg = sg && dn[n-1];
        dmag = dneg ? ((-dvd) & mask2) : dvd;
        vmag = vneg ? ((-dn) & mask) : dn;
        q = '0; r = '0;
        if (vmag == 0 || (dmag >> n) >= vmag) begin
            f = 1; lat = 2; return;
        end
        lat  = n + 2;
        qm   = dmag / vmag;
        rm   = dmag % vmag;
        half = 64'd1 << (n - 1);
        if (sg && ((dneg ^ vneg) ? (qm > half) : (qm >= half))) begin
            f = 1; return;
        end
        f = 0;
        q = 32'((sg && (dneg ^ vneg)) ? ((-qm) & mask) : qm);
        r = 32'((sg && dneg) ? ((-rm) & mask) : rm);
    endfunction

    task automatic run_op(input logic [1:0] sz, input bit sg, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] dv,
                          input bit inject, input string req);
        logic [31:0] eq, er, hq, hr;
        bit ef, hf;
        int elat, lat;
        model(sz, sg, hi, lo, dv, eq, er, ef, elat);
        @(negedge clk);
        size_sel = sz; signed_mode = sg; dvd_hi = hi; dvd_lo = lo; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (inject && lat == 3) begin
                start = 1'b1; divisor = '0; dvd_lo = ~lo; signed_mode = ~sg;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == elat, {req, " latency R5"}, 64'(lat), 64'(elat));
        chk(fault == ef, {req, " fault R8"}, 64'(fault), 64'(ef));
        chk(quotient == eq, {req, " quotient"}, 64'(quotient), 64'(eq));
        chk(remainder == er, {req, " remainder"}, 64'(remainder), 64'(er));
        chk(byte_result == {er[7:0], eq[7:0]}, {req, " packed R11"}, 64'(byte_result), 64'({er[7:0], eq[7:0]}));
        hq = quotient; hr = remainder; hf = fault;
        @(negedge clk);
        chk(!done && quotient == hq && remainder == hr && fault == hf, {req, " pulse/hold R9"},
            {31'd0, done, quotient}, {32'd0, hq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] sz;
        bit sg;
        logic [31:0] hi, lo, dv, msk;
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !busy && !fault && quotient == 0 && remainder == 0 && byte_result == 0,
            "R1 reset", {busy, done, fault, quotient}, 64'd0);

        run_op(2'd0, 0, 32'h0, 32'h64, 32'h7, 0, "R4 byte 100/7");
        run_op(2'd2, 0, 32'h1, 32'h0, 32'h3, 0, "R4 full 2^32/3");
        run_op(2'd1, 0, 32'h0, 32'hFFFF, 32'h1, 0, "R4 half max/1");
        run_op(2'd2, 0, 32'h12, 32'h3456, 32'h0, 0, "R2 zero divisor");
        run_op(2'd0, 1, 32'hFF, 32'h80, 32'h0, 0, "R2 signed zero divisor");
        run_op(2'd1, 0, 32'h5, 32'h0, 32'h5, 0, "R3 hi equals divisor");
        run_op(2'd2, 0, 32'hFFFF_FFFE, 32'h0, 32'hFFFF_FFFF, 0, "R3 hi just below divisor");
        run_op(2'd0, 1, 32'hFF, 32'hF9, 32'h02, 0, "R6 -7/2");
        run_op(2'd1, 1, 32'hFFFF, 32'hFFF9, 32'hFFFE, 0, "R6 -7/-2");
        run_op(2'd2, 1, 32'h0, 32'h7, 32'hFFFF_FFFE, 0, "R6 7/-2");
        run_op(2'd0, 1, 32'hFF, 32'h00, 32'h02, 0, "R7 -256/2 allowed");
        run_op(2'd0, 1, 32'h01, 32'h00, 32'h02, 0, "R7 256/2 faults");
        run_op(2'd0, 1, 32'hFF, 32'h80, 32'hFF, 0, "R7 -128/-1 faults");
        run_op(2'd2, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 0, "R7 full most negative");
        run_op(2'd0, 0, 32'hABCD_EF00, 32'h1234_5664, 32'hFFFF_FF07, 0, "R12 upper bits ignored");
        run_op(2'd3, 0, 32'h2, 32'h9, 32'h7, 0, "R4 size code 3");
        run_op(2'd2, 0, 32'h3, 32'hDEAD_BEEF, 32'h1234_5677, 1, "R10 start while busy");
        run_op(2'd1, 1, 32'hFFFF, 32'h8001, 32'h0101, 1, "R10 start while busy signed");

        for (int i = 0; i < 400; i++) begin
            sz  = 2'($urandom_range(0, 3));
            sg  = 1'($urandom);
            n   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
            msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
            dv  = $urandom;
            if ((dv & msk) == 0 && $urandom_range(0, 3) != 0) dv = dv | 32'd1;
            lo  = $urandom;
            if ($urandom_range(0, 3) != 0 && (dv & msk) != 0)
                hi = ($urandom & ~msk) | (($urandom & msk) % (dv & msk));
            else
                hi = $urandom;
            if (sg && $urandom_range(0, 1) == 1) hi = hi | msk;
            run_op(sz, sg, hi, lo, dv, ($urandom_range(0, 7) == 0), "R4 R6 R7 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule